// File: doc/BRIEF.md
# Serial Audio Transmitter (I2S)

This block turns 8, 16 or 32 bit audio samples into a serial I2S stream. It takes sample words from a first-word-fall-through FIFO that lies outside the block, and it drives the word-select (WS) and serial-data (SD) lines. All state moves on clock edges where the bit-clock enable is high, so the surrounding logic sets the bit rate by how often it raises that enable.

WS has two possible sources. In master mode an internal counter makes WS, and each WS level lasts a programmable number of bit ticks. In slave mode WS comes from an input pin. The control inputs also select mono operation (one sample goes out in both channels), mute (zeros go out but the framing and FIFO reads continue), stop (no FIFO reads and zero data) and a channel reset. The channel reset clears the transmitter and flushes the FIFO.

Each half frame begins with a WS transition. The most significant bit of the word goes out one bit tick after that transition. When the half frame is longer than the sample width, the remaining slots carry zeros.

Top module: `aud_i2s_tx`

## Requirements
- R1: After `rst`, the block holds `ws_out`=1, `sd_out`=0, `fifo_pop`=0 and `underrun`=0.
- R2: A clock edge with `bclk_en`=0 leaves `ws_out` and `sd_out` unchanged. The exception is an edge with `cfg_chan_rst` high.
- R3: With `cfg_ws_slave`=0, `ws_out` first toggles, to 0, on bit tick `cfg_half`+1 after reset. From then on it toggles every `cfg_half`+1 ticks. WS=0 is the left channel and WS=1 is the right channel.
- R4: In stereo, `fifo_pop` is high in the same cycle as each WS toggle tick, and `fifo_data` is taken in that cycle. Left is taken first. The word goes out MSB first, and its MSB appears on `sd_out` on the tick after the toggle.
- R5: `cfg_width` selects the sample: 00 sends `fifo_data[7:0]`, 01 sends `[15:0]`, and 10 or 11 sends `[31:0]`. Every slot of a half frame beyond the width is sent as 0.
- R6: With `cfg_mono`=1, one word is read on entry to each left half, and the same word is sent in the right half that follows.
- R7: With `cfg_mute`=1, `sd_out` stays 0. WS framing and FIFO reads continue unchanged.
- R8: With `cfg_stop`=1, the block makes no reads, `sd_out` stays 0, `underrun` is not set, and WS framing continues.
- R9: If a word is needed while `fifo_empty`=1, the block sends zeros for that half and sets `underrun`. The flag stays set until `rst` or `cfg_chan_rst`.
- R10: While `cfg_chan_rst`=1, `fifo_flush` is high and no read is made. At the next clock edge, whatever the value of `bclk_en`, `ws_out` becomes 1, `sd_out` becomes 0 and `underrun` becomes 0. The master counter then starts again from zero.
- R11: With `cfg_ws_slave`=1, the block samples `ws_in` on each tick and drives the sampled value on `ws_out`. A change seen on a tick starts a half frame in the same way as a master toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_en | input | 1 | Bit tick enable, one clock per bit clock period |
| cfg_width | input | 2 | Sample width code |
| cfg_mono | input | 1 | Mono: one sample feeds both channels |
| cfg_stop | input | 1 | Halt FIFO reads and send zeros |
| cfg_chan_rst | input | 1 | Clear the channel and flush the FIFO |
| cfg_ws_slave | input | 1 | Take WS from `ws_in` |
| cfg_half | input | HALF_W | WS half period in ticks, minus one |
| cfg_mute | input | 1 | Send zeros while framing continues |
| ws_in | input | 1 | External WS in slave mode |
| fifo_data | input | 32 | Head word of the sample FIFO |
| fifo_empty | input | 1 | FIFO has no word |
| fifo_pop | output | 1 | Consume the head word this cycle |
| fifo_flush | output | 1 | Discard all FIFO contents |
| ws_out | output | 1 | Word select |
| sd_out | output | 1 | Serial data |
| underrun | output | 1 | Sticky FIFO underrun flag |

## Verification
Two things can fall on the same tick: the last slot bit of one half frame is shifted out, and the next word is read and loaded. In 32-bit mode with `cfg_half`=31 every data slot is used, so this happens on every WS toggle tick. The bench runs that case, rebuilds each word from `sd_out`, and compares it with the FIFO contents. A missing LSB or a lost MSB shows up as a word mismatch. A channel reset applied mid-frame without a bit tick also checks that R10 does not wait for `bclk_en`.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;

    localparam int SAMPLE_W = 32;
    localparam int POS_W    = $clog2(SAMPLE_W);
    localparam int IDX_W    = POS_W + 1;

    typedef logic [IDX_W-1:0] idx_t;
    localparam idx_t IDX_MAX = '1;

    typedef enum logic [1:0] {
        WID_8   = 2'b00,
        WID_16  = 2'b01,
        WID_32  = 2'b10,
        WID_32R = 2'b11
    } width_e;

    typedef struct packed {
        width_e width;
        logic   mono;
        logic   stop;
        logic   chan_rst;
        logic   ws_slave;
        logic   mute;
    } tx_mode_t;

    function automatic idx_t width_bits(width_e w);
        unique case (w)
            WID_8:   return idx_t'(8);
            WID_16:  return idx_t'(16);
            default: return idx_t'(SAMPLE_W);
        endcase
    endfunction

endpackage

// File: rtl/aud_tx_wsgen.sv
module aud_tx_wsgen
    import aud_tx_pkg::*;
#(
    parameter int HALF_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              crst,
    input  logic              slave,
    input  logic [HALF_W-1:0] half,
    input  logic              ws_pin,
    output logic              ws,
    output logic              wsflip,
    output logic              new_ws
);

    logic [HALF_W-1:0] cnt;
    logic              ws_q;

    always_ff @(posedge clk) begin
        if (rst || crst) begin
            cnt  <= '0;
            ws_q <= 1'b1;
        end else if (tick) begin
            if (slave) begin
                ws_q <= ws_pin;
                cnt  <= '0;
            end else if (cnt == half) begin
                ws_q <= ~ws_q;
                cnt  <= '0;
            end else begin
                cnt  <= cnt + 1'b1;
            end
        end
    end

    always_comb begin
        wsflip = tick && !crst && (slave ? (ws_pin != ws_q) : (cnt == half));
        new_ws = slave ? ws_pin : ~ws_q;
    end

    assign ws = ws_q;

    // R3
    ws_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!slave && !crst && tick && cnt != half) |=> $stable(ws_q));

    // R2
    ws_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !crst) |=> $stable(ws_q));

    // R10
    ws_crst_chk: assert property (@(posedge clk) disable iff (rst)
        crst |=> (ws_q && cnt == '0));

endmodule

// File: rtl/aud_tx_fetch.sv
module aud_tx_fetch
    import aud_tx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                crst,
    input  logic                wsflip,
    input  logic                new_ws,
    input  logic                mono,
    input  logic                stop,
    input  logic                fifo_empty,
    input  logic [SAMPLE_W-1:0] fifo_data,
    output logic                pop,
    output logic [SAMPLE_W-1:0] word,
    output logic                underrun
);

    logic [SAMPLE_W-1:0] hold;
    logic                need;
    logic                unr_q;

    always_comb begin
        need = wsflip && !stop && (!mono || !new_ws);
        pop  = need && !fifo_empty;
        if (stop)
            word = '0;
        else if (mono && new_ws)
            word = hold;
        else if (fifo_empty)
            word = '0;
        else
            word = fifo_data;
    end

    always_ff @(posedge clk) begin
        if (rst || crst) begin
            hold  <= '0;
            unr_q <= 1'b0;
        end else begin
            if (wsflip && mono && !new_ws)
                hold <= word;
            if (need && fifo_empty)
                unr_q <= 1'b1;
        end
    end

    assign underrun = unr_q;

    // R8
    stop_pop_chk: assert property (@(posedge clk) disable iff (rst)
        stop |-> !pop);

    // R9
    unr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (unr_q && !crst) |=> unr_q);

    // R6
    mono_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (mono && pop) |-> !new_ws);

    // R8
    stop_unr_chk: assert property (@(posedge clk) disable iff (rst)
        (stop && !unr_q) |=> !unr_q);

endmodule

// File: rtl/aud_tx_shift.sv
module aud_tx_shift
    import aud_tx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                crst,
    input  logic                wsflip,
    input  logic                quiet,
    input  width_e              width,
    input  logic [SAMPLE_W-1:0] word_i,
    output logic                sd
);

    idx_t                idx;
    idx_t                wb;
    idx_t                pos_full;
    logic [POS_W-1:0]    pos;
    logic [SAMPLE_W-1:0] sreg;
    logic                sd_q;
    logic                bit_now;

    always_comb begin
        wb       = width_bits(width);
        pos_full = wb - idx - idx_t'(1);
        pos      = pos_full[POS_W-1:0];
        bit_now  = (idx < wb) && !quiet && sreg[pos];
    end

    always_ff @(posedge clk) begin
        if (rst || crst) begin
            idx  <= IDX_MAX;
            sreg <= '0;
            sd_q <= 1'b0;
        end else if (tick) begin
            sd_q <= bit_now;
            if (wsflip) begin
                idx  <= '0;
                sreg <= word_i;
            end else if (idx != IDX_MAX) begin
                idx  <= idx + idx_t'(1);
            end
        end
    end

    assign sd = sd_q;

    // R7
    quiet_sd_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && quiet && !crst) |=> !sd_q);

    // R2
    sd_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !crst) |=> $stable(sd_q));

    // R5
    pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !crst && idx >= wb) |=> !sd_q);

endmodule

// File: rtl/aud_i2s_tx.sv
module aud_i2s_tx
    import aud_tx_pkg::*;
#(
    parameter int HALF_W = 9
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bclk_en,
    input  logic [1:0]          cfg_width,
    input  logic                cfg_mono,
    input  logic                cfg_stop,
    input  logic                cfg_chan_rst,
    input  logic                cfg_ws_slave,
    input  logic [HALF_W-1:0]   cfg_half,
    input  logic                cfg_mute,
    input  logic                ws_in,
    input  logic [SAMPLE_W-1:0] fifo_data,
    input  logic                fifo_empty,
    output logic                fifo_pop,
    output logic                fifo_flush,
    output logic                ws_out,
    output logic                sd_out,
    output logic                underrun
);

    tx_mode_t            mode;
    logic                wsflip;
    logic                new_ws;
    logic [SAMPLE_W-1:0] next_word;

    always_comb begin
        mode.width    = width_e'(cfg_width);
        mode.mono     = cfg_mono;
        mode.stop     = cfg_stop;
        mode.chan_rst = cfg_chan_rst;
        mode.ws_slave = cfg_ws_slave;
        mode.mute     = cfg_mute;
    end

    assign fifo_flush = mode.chan_rst;

    aud_tx_wsgen #(.HALF_W(HALF_W)) u_wsgen (
        .clk    (clk),
        .rst    (rst),
        .tick   (bclk_en),
        .crst   (mode.chan_rst),
        .slave  (mode.ws_slave),
        .half   (cfg_half),
        .ws_pin (ws_in),
        .ws     (ws_out),
        .wsflip (wsflip),
        .new_ws (new_ws)
    );

    aud_tx_fetch u_fetch (
        .clk        (clk),
        .rst        (rst),
        .crst       (mode.chan_rst),
        .wsflip     (wsflip),
        .new_ws     (new_ws),
        .mono       (mode.mono),
        .stop       (mode.stop),
        .fifo_empty (fifo_empty),
        .fifo_data  (fifo_data),
        .pop        (fifo_pop),
        .word       (next_word),
        .underrun   (underrun)
    );

    aud_tx_shift u_shift (
        .clk    (clk),
        .rst    (rst),
        .tick   (bclk_en),
        .crst   (mode.chan_rst),
        .wsflip (wsflip),
        .quiet  (mode.mute || mode.stop),
        .width  (mode.width),
        .word_i (next_word),
        .sd     (sd_out)
    );

    // R10
    flush_nopop_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_chan_rst |-> !fifo_pop);

endmodule

// File: tb/aud_i2s_tx_bench.sv
`timescale 1ns/1ps
module aud_i2s_tx_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bclk_en = 1'b0;
    logic [1:0]  cfg_width = 2'b01;
    logic        cfg_mono = 1'b0, cfg_stop = 1'b0, cfg_chan_rst = 1'b0;
    logic        cfg_ws_slave = 1'b0, cfg_mute = 1'b0;
    logic [8:0]  cfg_half = 9'd19;
    logic        ws_in = 1'b1;
    logic [31:0] fifo_data;
    logic        fifo_empty, fifo_pop, fifo_flush, ws_out, sd_out, underrun;

    always #10 clk = ~clk;

    logic [31:0] fq [0:15];
    logic [31:0] ex [0:15];
    int fcnt = 0;
    int fhead = 0;
    int checks = 0, errors = 0;
    int tk = 0, slot_len = 20, slotno = 0;
    bit slave_drive = 1'b0;
    bit done = 1'b0;

    assign fifo_empty = (fhead >= fcnt);
    assign fifo_data  = fifo_empty ? 32'h0 : fq[fhead[3:0]];

    always @(posedge clk) begin
        if (rst) fhead <= 0;
        else if (fifo_flush) fhead <= fcnt;
        else if (fifo_pop) fhead <= fhead + 1;
    end

    aud_i2s_tx u_aud_i2s_tx (
        .clk(clk), .rst(rst), .bclk_en(bclk_en), .cfg_width(cfg_width),
        .cfg_mono(cfg_mono), .cfg_stop(cfg_stop), .cfg_chan_rst(cfg_chan_rst),
        .cfg_ws_slave(cfg_ws_slave), .cfg_half(cfg_half), .cfg_mute(cfg_mute),
        .ws_in(ws_in), .fifo_data(fifo_data), .fifo_empty(fifo_empty),
        .fifo_pop(fifo_pop), .fifo_flush(fifo_flush), .ws_out(ws_out),
        .sd_out(sd_out), .underrun(underrun)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic push(logic [31:0] w);
        fq[fcnt[3:0]] = w;
        fcnt++;
    endtask

    task automatic tick();
        if (slave_drive) ws_in = ((tk / slot_len) % 2) != 0;
        bclk_en = 1'b1;
        @(posedge clk); @(negedge clk);
        bclk_en = 1'b0;
        tk++;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic setup(logic [1:0] w, bit mono, bit stop, bit mute, bit slave, int half);
        rst = 1'b1;
        bclk_en = 1'b0;
        cfg_width = w; cfg_mono = mono; cfg_stop = stop; cfg_mute = mute;
        cfg_ws_slave = slave; cfg_half = 9'(half); cfg_chan_rst = 1'b0;
        ws_in = 1'b1;
        slave_drive = slave;
        slot_len = slave ? 20 : half + 1;
        fcnt = 0; slotno = 0; tk = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Run nslots half frames; pre ticks reach the first toggle. Slot k carries ex[k].
    task automatic run_slots(int nslots, int pre, int w, string req);
        logic [31:0] m;
        m = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
        for (int p = 0; p < pre; p++) begin
            if (p == pre - 1 && !slave_drive) chk("R3 ws before first toggle", 32'(ws_out), 32'h1);
            tick();
        end
        if (pre > 0) chk("R3 ws after first toggle", 32'(ws_out), 32'h0);
        for (int n = 0; n < nslots; n++) begin
            logic [31:0] got;
            logic        pad;
            got = '0; pad = 1'b0;
            for (int j = 0; j < slot_len; j++) begin
                tick();
                if (j == 0) chk({req, " R3/R11 ws level"}, 32'(ws_out), 32'(slotno % 2));
                if (j < w) got = {got[30:0], sd_out};
                else pad = pad | sd_out;
            end
            chk({req, " word"}, got & m, ex[slotno[3:0]] & m);
            if (slot_len > w) chk("R5 padding zero", 32'(pad), 32'h0);
            slotno++;
        end
    endtask

    task automatic t_reset();
        setup(2'b01, 0, 0, 0, 0, 19);
        chk("R1 ws_out", 32'(ws_out), 32'h1);
        chk("R1 sd_out", 32'(sd_out), 32'h0);
        chk("R1 fifo_pop", 32'(fifo_pop), 32'h0);
        chk("R1 underrun", 32'(underrun), 32'h0);
    endtask

    task automatic t_stereo16();
        logic ws_b, sd_b;
        setup(2'b01, 0, 0, 0, 0, 19);
        push(32'hDEAD_A5C3); push(32'h1234_8001); push(32'hFFFF_7FFE);
        push(32'h0000_C00C); push(32'h5555_AAAA); push(32'h0F0F_F0F0);
        for (int i = 0; i < 6; i++) ex[i] = fq[i];
        run_slots(4, 20, 16, "R4 stereo16");
        chk("R9 no underrun", 32'(underrun), 32'h0);
        repeat (3) tick();
        ws_b = ws_out; sd_b = sd_out;
        repeat (10) @(negedge clk);
        chk("R2 ws idle", 32'(ws_out), 32'(ws_b));
        chk("R2 sd idle", 32'(sd_out), 32'(sd_b));
    endtask

    task automatic t_width8();
        setup(2'b00, 0, 0, 0, 0, 11);
        push(32'hFFFF_FF81); push(32'hAAAA_AA7E); push(32'h1234_5655); push(32'h0000_00C3); push(32'h0);
        for (int i = 0; i < 5; i++) ex[i] = fq[i];
        run_slots(4, 12, 8, "R5 width8");
    endtask

    task automatic t_width32(logic [1:0] code, int half);
        setup(code, 0, 0, 0, 0, half);
        push(32'h8000_0001); push(32'hC3A5_5A3C); push(32'h7FFF_FFFE); push(32'hFEDC_BA98); push(32'h0);
        for (int i = 0; i < 5; i++) ex[i] = fq[i];
        run_slots(4, half + 1, 32, "R5 width32");
    endtask

    task automatic t_mono();
        setup(2'b01, 1, 0, 0, 0, 17);
        push(32'h0000_9A61); push(32'h0000_3CC3); push(32'h0000_1111);
        ex[0] = 32'h9A61; ex[1] = 32'h9A61; ex[2] = 32'h3CC3; ex[3] = 32'h3CC3;
        run_slots(4, 18, 16, "R6 mono");
        chk("R6 mono reads", 32'(fhead), 32'd3);
    endtask

    task automatic t_mute();
        setup(2'b01, 0, 0, 1, 0, 15);
        for (int i = 0; i < 6; i++) begin push(32'hFFFF_FFFF); ex[i] = 32'h0; end
        run_slots(4, 16, 16, "R7 mute");
        chk("R7 mute still reads", 32'(fhead), 32'd5);
    endtask

    task automatic t_stop();
        setup(2'b01, 0, 1, 0, 0, 15);
        for (int i = 0; i < 3; i++) begin push(32'hFFFF_FFFF); ex[i] = 32'h0; end
        ex[3] = 32'h0;
        run_slots(4, 16, 16, "R8 stop");
        chk("R8 stop no reads", 32'(fhead), 32'd0);
        chk("R8 stop no underrun", 32'(underrun), 32'h0);
    endtask

    task automatic t_underrun_and_chanrst();
        setup(2'b01, 0, 0, 0, 0, 15);
        push(32'h0000_F00F); push(32'h0000_8421);
        ex[0] = 32'hF00F; ex[1] = 32'h8421; ex[2] = 32'h0; ex[3] = 32'h0;
        run_slots(4, 16, 16, "R9 underrun zeros");
        chk("R9 underrun set", 32'(underrun), 32'h1);
        push(32'h0000_BEEF); push(32'h0000_0FF0);
        ex[4] = 32'h0; ex[5] = 32'hBEEF;
        run_slots(2, 0, 16, "R9 recovery");
        chk("R9 underrun sticky", 32'(underrun), 32'h1);
        repeat (3) tick();
        cfg_chan_rst = 1'b1;
        #1;
        chk("R10 flush high", 32'(fifo_flush), 32'h1);
        chk("R10 no pop", 32'(fifo_pop), 32'h0);
        @(posedge clk); @(negedge clk);
        chk("R10 ws_out", 32'(ws_out), 32'h1);
        chk("R10 sd_out", 32'(sd_out), 32'h0);
        chk("R10 underrun cleared", 32'(underrun), 32'h0);
        chk("R10 fifo flushed", 32'(fifo_empty), 32'h1);
        cfg_chan_rst = 1'b0;
        push(32'h0000_6996); push(32'h0000_A00A); push(32'h0000_1234);
        slotno = 0;
        ex[0] = 32'h6996; ex[1] = 32'hA00A;
        run_slots(2, 16, 16, "R10 restart");
    endtask

    task automatic t_slave();
        setup(2'b01, 0, 0, 0, 1, 3);
        push(32'h0000_ACE1); push(32'h0000_1357); push(32'h0000_FFFF); push(32'h0000_8000); push(32'h0);
        for (int i = 0; i < 5; i++) ex[i] = fq[i];
        run_slots(4, 1, 16, "R11 slave");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_stereo16();
        t_width8();
        t_width32(2'b10, 31);
        t_width32(2'b11, 33);
        t_mono();
        t_mute();
        t_stop();
        t_underrun_and_chanrst();
        t_slave();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule